// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock period. In that period it fetches a word from its private instruction store, decodes it, reads two operands from a 32-entry register file, runs them through an add/subtract/OR unit, optionally touches its private data store, and on the closing rising edge writes the result register and the new program counter. Six operations are recognised: register add, register subtract, OR with an immediate, word load, word store and branch-on-equal. Anything else passes through as a no-op.

Both stores hold 256 words and are filled through a loader port that is honoured only while reset is asserted. After reset is released, the core runs from word 0. Two debug outputs let a bench follow execution: the current program counter, and the register write that the next rising edge will commit.

Top module: `sc_core`

## Requirements
- R1: Synchronous active-high reset sets the program counter to 0 and clears every register. While reset is high, the loader writes word `ld_addr` of the instruction store (`ld_sel`=0) or of the data store (`ld_sel`=1) on each edge where `ld_en` is 1. With reset low, the loader has no effect on either store.
- R2: Opcode 0x00 (bits 31:26) with function code 0x21 (bits 5:0) writes rs+rt to rd, and function code 0x23 writes rs-rt to rd. Sources are at bits 25:21 and 20:16, the destination at bits 15:11, and results wrap modulo 2^32.
- R3: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits 15:0) to rt.
- R4: Opcode 0x23 writes to rt the data-store word at rs + sign-extended immediate. Bits 9:2 of that sum select the word.
- R5: Opcode 0x2B writes rt into the data-store word at rs + sign-extended immediate on the closing edge. A later load from that word returns the stored value.
- R6: Opcode 0x04 with rs equal to rt sets the next program counter to PC+4+(sign-extended immediate shifted left by 2). The equality test is the zero result of rs-rt, so a negative offset branches backwards.
- R7: Every instruction that is not a taken branch advances the program counter by 4. This includes a branch-on-equal whose operands differ.
- R8: Register 0 always reads as zero, and a write aimed at it is discarded.
- R9: An unrecognised opcode, or opcode 0x00 with any other function code, writes no register, writes no data-store word and advances the program counter by 4.
- R10: `dbg_pc` shows the current program counter. `dbg_wr_en` is 1 exactly when the current instruction will write a nonzero register on the next edge, with `dbg_wr_idx` and `dbg_wr_val` giving the destination and the value.
- R11: A register written by one instruction supplies the new value to the operand read of the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables the loader |
| ld_en | input | 1 | Loader write strobe, honoured only while reset is high |
| ld_sel | input | 1 | Loader target: 0 instruction store, 1 data store |
| ld_addr | input | 8 | Loader word index |
| ld_data | input | 32 | Loader word value |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A nonzero register is written at the next edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_val | output | 32 | Value of that write |

## Verification
The clock edge that commits one instruction's register or store write is the same edge that brings the next instruction in, so write-back and the following operand read meet at one boundary. The program chains dependent instructions back to back: a sum feeds a subtract, a store is followed at once by a load of the same word, and a loaded value feeds a branch comparison. A behavioural model in the bench steps alongside the core and compares the program counter and the announced register write on every cycle. A wrong value at any of these meetings shows up as a mismatch in the cycle it occurs.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN    = 32;
    localparam int RIDX_W  = 5;

    localparam logic [5:0] OPC_REG   = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h21;
    localparam logic [5:0] FN_SUB = 6'h23;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_is_rd;
        logic    use_imm;
        logic    sext;
        logic    wb_mem;
        logic    mem_we;
        logic    is_branch;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OPC_REG: begin
                if (funct == FN_ADD) begin
                    ctrl.reg_we    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.alu_op    = ALU_ADD;
                end else if (funct == FN_SUB) begin
                    ctrl.reg_we    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.alu_op    = ALU_SUB;
                end
            end
            OPC_ORI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OPC_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.sext    = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.sext    = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.sext      = 1'b1;
                ctrl.alu_op    = ALU_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
        zero = (y == '0);
    end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W       = 32,
    parameter int ENTRIES = 32,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs_q [ENTRIES];
    logic [W-1:0] regs_d [ENTRIES];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) regs_d[wa] = wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a = regs_q[ra];
    assign rd_b = regs_q[rb];

    // R8: entry zero never holds anything but zero
    assert_zero_reg_R8: assert property (@(posedge clk) disable iff (rst)
        (ra == '0) |-> (rd_a == '0));

    // R11: a write lands and is visible on the following cycle
    assert_write_visible_R11: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> (regs_q[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem #(
    parameter int W     = 32,
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [WORDS];
    logic [W-1:0] mem_d [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) mem_q <= mem_d;

    assign rdata = mem_q[raddr];

    // R5: an enabled write is held in the addressed word afterwards
    assert_store_lands_R5: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic              dbg_wr_en,
    output logic [RIDX_W-1:0] dbg_wr_idx,
    output logic [XLEN-1:0]   dbg_wr_val
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [XLEN-1:0]   instr;
    logic [RIDX_W-1:0] f_rs, f_rt, f_rd;
    logic [15:0]       f_imm;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val, rt_val, ext_imm, alu_b, alu_y, dm_rdata, wb_val;
    logic              alu_zero, take_br;
    logic [RIDX_W-1:0] dst_idx;
    logic [XLEN-1:0]   pc_plus4, br_target;
    logic              im_we, dm_we;
    logic [MEM_AW-1:0] dm_waddr;
    logic [XLEN-1:0]   dm_wdata;
    logic              unused_shamt;

    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_imm = instr[15:0];
    assign unused_shamt = ^instr[10:6];

    sc_wordmem #(.W(XLEN), .WORDS(MEM_WORDS)) u_imem (
        .clk   (clk),
        .rst   (rst),
        .we    (im_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (st_q.pc[MEM_AW+1:2]),
        .rdata (instr)
    );

    sc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    sc_regfile #(.W(XLEN), .ENTRIES(1 << RIDX_W)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra   (f_rs),
        .rb   (f_rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (ctrl.reg_we),
        .wa   (dst_idx),
        .wd   (wb_val)
    );

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    sc_wordmem #(.W(XLEN), .WORDS(MEM_WORDS)) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[MEM_AW+1:2]),
        .rdata (dm_rdata)
    );

    always_comb begin
        ext_imm   = ctrl.sext ? {{(XLEN-16){f_imm[15]}}, f_imm} : {{(XLEN-16){1'b0}}, f_imm};
        alu_b     = ctrl.use_imm ? ext_imm : rt_val;
        wb_val    = ctrl.wb_mem ? dm_rdata : alu_y;
        dst_idx   = ctrl.dst_is_rd ? f_rd : f_rt;
        take_br   = ctrl.is_branch && alu_zero;
        pc_plus4  = st_q.pc + XLEN'(4);
        br_target = pc_plus4 + {ext_imm[XLEN-3:0], 2'b00};

        im_we    = rst && ld_en && !ld_sel;
        dm_we    = rst ? (ld_en && ld_sel) : ctrl.mem_we;
        dm_waddr = rst ? ld_addr : alu_y[MEM_AW+1:2];
        dm_wdata = rst ? ld_data : rt_val;

        st_d    = st_q;
        st_d.pc = take_br ? br_target : pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dbg_pc     = st_q.pc;
    assign dbg_wr_en  = !rst && ctrl.reg_we && (dst_idx != '0);
    assign dbg_wr_idx = dst_idx;
    assign dbg_wr_val = wb_val;

    // R1: first cycle out of reset starts at address zero
    assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (st_q.pc == '0));

    // R7: anything but a taken branch steps by one word
    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> (st_q.pc == $past(st_q.pc) + XLEN'(4)));

    // R6: a taken branch needs equal register operands
    assert_branch_equal_R6: assert property (@(posedge clk) disable iff (rst)
        take_br |-> (rs_val == rt_val));

    // R9: a no-op cycle commits nothing
    assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.reg_we && !ctrl.mem_we && !ctrl.is_branch) |-> !dbg_wr_en);
endmodule

// File: tb/sc_core_tb.sv
`timescale 1ns/1ps
module sc_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc;
    logic        dbg_wr_en;
    logic [4:0]  dbg_wr_idx;
    logic [31:0] dbg_wr_val;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sc_core u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_idx(dbg_wr_idx), .dbg_wr_val(dbg_wr_val)
    );

    // behavioural reference state
    logic [31:0] m_imem [256];
    logic [31:0] m_dmem [256];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;
    int          last_wr = 0;
    int          last_st = -1;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic load_word(bit sel, int addr, logic [31:0] data);
        ld_en = 1'b1; ld_sel = sel; ld_addr = 8'(addr); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // compare the current cycle, then advance the model over the coming edge
    task automatic step_and_compare();
        logic [31:0] ins, a, b, sx, addr, val, npc;
        logic [5:0]  op, fn;
        int          rs, rt, rd, dst;
        bit          we, mwe, br, nop;
        string       tag;
        ins = m_imem[m_pc[9:2]];
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_reg[rs]; b = m_reg[rt];
        sx = {{16{ins[15]}}, ins[15:0]};
        we = 0; mwe = 0; br = 0; nop = 0; dst = 0; val = '0; addr = a + sx;
        npc = m_pc + 4; tag = "R9";
        if (op == 6'h00 && fn == 6'h21) begin we = 1; dst = rd; val = a + b; tag = "R2"; end
        else if (op == 6'h00 && fn == 6'h23) begin we = 1; dst = rd; val = a - b; tag = "R2"; end
        else if (op == 6'h0D) begin we = 1; dst = rt; val = a | {16'h0, ins[15:0]}; tag = "R3"; end
        else if (op == 6'h23) begin
            we = 1; dst = rt; val = m_dmem[addr[9:2]]; tag = "R4";
            if (int'(addr[9:2]) == last_st) tag = "R5";
            if (addr[9:2] == 8'd1) tag = "R1";
        end
        else if (op == 6'h2B) begin mwe = 1; tag = "R5"; end
        else if (op == 6'h04) begin br = 1; tag = "R6"; if (a == b) npc = m_pc + 4 + (sx << 2); end
        else nop = 1;
        if (we && dst == 0) tag = "R8";
        else if (we && tag != "R5" && tag != "R1" && last_wr != 0 && (rs == last_wr || rt == last_wr)) tag = "R11";

        check(dbg_pc == m_pc, br ? "R6" : (nop ? "R9" : "R7"), "pc", dbg_pc, m_pc);
        check(dbg_wr_en == (we && dst != 0), (nop || we && dst == 0) ? tag : "R10", "wr_en",
              32'(dbg_wr_en), 32'(we && dst != 0));
        if (we && dst != 0) begin
            check(dbg_wr_idx == 5'(dst), tag, "wr_idx", 32'(dbg_wr_idx), 32'(dst));
            check(dbg_wr_val == val, tag, "wr_val", dbg_wr_val, val);
        end

        if (we && dst != 0) m_reg[dst] = val;
        last_wr = (we && dst != 0) ? dst : 0;
        if (mwe) begin m_dmem[addr[9:2]] = b; last_st = int'(addr[9:2]); end
        m_pc = npc;
    endtask

    initial begin
        logic [31:0] prog [17];
        prog[0]  = enc_i(6'h0D, 0, 1, 16'h8005);       // r1 = 0x8005, zero-extended
        prog[1]  = enc_i(6'h0D, 0, 2, 16'h0003);       // r2 = 3
        prog[2]  = enc_r(1, 2, 3, 6'h21);              // r3 = r1 + r2
        prog[3]  = enc_r(2, 1, 4, 6'h23);              // r4 = r2 - r1 (wraps)
        prog[4]  = enc_i(6'h2B, 0, 3, 16'h0008);       // store r3 to word 2
        prog[5]  = enc_i(6'h23, 0, 5, 16'h0008);       // load it straight back
        prog[6]  = enc_i(6'h23, 7, 6, 16'hFFFC);       // address -4 -> word 255
        prog[7]  = enc_r(1, 2, 0, 6'h21);              // write to r0 discarded
        prog[8]  = enc_r(0, 0, 8, 6'h21);              // r8 = r0 + r0
        prog[9]  = enc_i(6'h04, 3, 5, 16'h0001);       // equal: skip next
        prog[10] = enc_i(6'h0D, 0, 9, 16'hDEAD);       // skipped
        prog[11] = enc_i(6'h04, 1, 2, 16'h0005);       // unequal: fall through
        prog[12] = 32'hFC00_0000;                      // unknown opcode
        prog[13] = enc_r(1, 2, 12, 6'h25);             // unknown function code
        prog[14] = enc_i(6'h23, 0, 10, 16'h0004);      // load word 1
        prog[15] = enc_r(10, 10, 11, 6'h23);           // r11 = 0
        prog[16] = enc_i(6'h04, 11, 0, 16'hFFEF);      // backward branch to 0

        for (int i = 0; i < 256; i++) begin m_imem[i] = '0; m_dmem[i] = '0; end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        for (int i = 0; i < 17; i++) m_imem[i] = prog[i];
        m_dmem[1] = 32'h1234_5678; m_dmem[2] = 32'h0; m_dmem[255] = 32'hCAFE_F00D;
        m_pc = '0;

        @(negedge clk);
        for (int i = 0; i < 17; i++) load_word(1'b0, i, prog[i]);
        load_word(1'b1, 1, 32'h1234_5678);
        load_word(1'b1, 2, 32'h0);
        load_word(1'b1, 255, 32'hCAFE_F00D);

        // R1: program counter held at zero while in reset
        #1 check(dbg_pc == 32'h0, "R1", "reset pc", dbg_pc, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int cyc = 0; cyc < 120; cyc++) begin
            step_and_compare();
            // R1: loader strobes out of reset must not reach either store
            if (cyc == 3) begin ld_en = 1; ld_sel = 1; ld_addr = 8'd1; ld_data = 32'hBAD0_BAD0; end
            else if (cyc == 4) begin ld_en = 1; ld_sel = 0; ld_addr = 8'd15; ld_data = 32'h3409_FFFF; end
            else ld_en = 0;
            @(negedge clk);
            #1;
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule